// File: doc/BRIEF.md
# Multiplexed Display Scan Timer

This block paces the time-multiplexed refresh of an eight-position character display. A slow oscillator tick, given as a one-cycle enable on the system clock, feeds a divide-by-64 prescaler. Each prescaler wrap advances a position counter that steps through the character positions in order. The position counter supplies the read address of the character memory. It is also decoded into a one-hot set of character enables, and a segment enable runs beside them.

Each character slot opens with a short blanking gap, one oscillator tick long, in which every character enable is off. This keeps the segment data of the previous position from ghosting onto the next one. While a host write is in progress, signalled by `wr_busy`, both the character and segment outputs are held off, but the scan keeps counting. A shutdown level turns every output off and clears the prescaler and position counter. When shutdown is released, scanning starts again at position 0. All outputs come from registers, so the enables change cleanly at slot boundaries.

Top module: `display_scan_timer`

## Requirements
- R1: While `rst` is high, `scan_addr` is 0, `char_en` is all zero and `seg_en` is low.
- R2: The position counter advances only on the 64th accepted oscillator tick of a prescaler period. Clock cycles without `osc_tick` leave `scan_addr` unchanged.
- R3: `scan_addr` steps 0,1,...,7 and then wraps back to 0, one step for each prescaler wrap.
- R4: When not blanked, not writing and not shut down, `char_en` one clock later equals the one-hot decode of the scan position. Bit 0 is position 0, the leftmost character, and bit n is position n.
- R5: While the prescaler count is 0 (the first tick period of each slot), `char_en` one clock later is all zero. `seg_en` is not affected by this blanking.
- R6: In the cycle after `wr_busy` is sampled high, `char_en` is all zero and `seg_en` is low. Counting continues during a write.
- R7: In the cycle after `shutdown` is sampled high, the prescaler and position counter are 0, `char_en` is all zero and `seg_en` is low. After release, the scan resumes at position 0, starting with a blanking gap.
- R8: At most one bit of `char_en` is ever set.
- R9: With a tick on every clock, each character enable stays on for 63 consecutive cycles, and one position recurs every 512 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle oscillator tick enable |
| shutdown | input | 1 | High level puts the block in the idle, outputs-off state |
| wr_busy | input | 1 | Qualifying host write in progress; suppresses outputs |
| scan_addr | output | 3 | Character memory read address (scan position) |
| char_en | output | 8 | One-hot character enable, bit 0 = leftmost |
| seg_en | output | 1 | Segment output enable |

## Verification
The embedded properties check, on every clock, that `char_en` has at most one bit set. They also check that write and shutdown force the outputs off one cycle later, that the prescaler holds without a tick, that the position only steps on a prescaler wrap and in order, and that shutdown clears the counters. The bench's cycle model alone shows the timing seen from the ports. This covers the 63-cycle enable width and the 512-cycle frame, the choice of position 0 for the leftmost bit, the resume at position 0 behind a blanking gap after shutdown, and correct output under random tick density mixed with write and shutdown bursts.

// File: rtl/dscan_pkg.sv
package dscan_pkg;

  localparam int unsigned DEF_PRESCALE  = 64;
  localparam int unsigned DEF_POSITIONS = 8;
  localparam int unsigned DEF_BLANK     = 1;

  // Why the outputs are (or are not) showing, in falling priority.
  typedef enum logic [1:0] {
    GATE_OFF   = 2'd0,
    GATE_WRITE = 2'd1,
    GATE_BLANK = 2'd2,
    GATE_SHOW  = 2'd3
  } gate_e;

  function automatic gate_e pick_gate(input logic sd, input logic busy, input logic blank);
    if (sd)         return GATE_OFF;
    else if (busy)  return GATE_WRITE;
    else if (blank) return GATE_BLANK;
    else            return GATE_SHOW;
  endfunction

endpackage

// File: rtl/dscan_prescaler.sv
module dscan_prescaler #(
  parameter int unsigned PRESCALE    = 64,
  parameter int unsigned BLANK_TICKS = 1,
  localparam int unsigned PRE_W      = $clog2(PRESCALE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clear,
  output logic [PRE_W-1:0] count,
  output logic             wrap,
  output logic             blank
);

  localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign count = cnt_q;
  assign wrap  = tick && !clear && (cnt_q == LAST);
  assign blank = (cnt_q < PRE_W'(BLANK_TICKS));

  // R2: no tick, no movement
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clear) |=> $stable(cnt_q));

  // R7: shutdown clears the prescaler
  a_r7_pre_clear: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt_q == '0));

endmodule

// File: rtl/dscan_position.sv
module dscan_position #(
  parameter int unsigned POSITIONS = 8,
  localparam int unsigned POS_W    = $clog2(POSITIONS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             clear,
  output logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] LAST = POS_W'(POSITIONS - 1);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pos_q <= '0;
    end else if (step) begin
      pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end
  end

  assign pos = pos_q;

  // R3: each step moves exactly one position forward, wrapping after the last
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (step && !clear) |=> (pos_q == (($past(pos_q) == LAST) ? '0 : $past(pos_q) + 1'b1)));

  // R2: the position holds between prescaler wraps
  a_r2_no_step: assert property (@(posedge clk) disable iff (rst)
    (!step && !clear) |=> $stable(pos_q));

  // R7: shutdown returns the scan to position 0
  a_r7_pos_clear: assert property (@(posedge clk) disable iff (rst)
    clear |=> (pos_q == '0));

endmodule

// File: rtl/dscan_outputs.sv
module dscan_outputs
  import dscan_pkg::*;
#(
  parameter int unsigned POSITIONS = 8,
  localparam int unsigned POS_W    = $clog2(POSITIONS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [POS_W-1:0]     pos,
  input  logic                 blank,
  input  logic                 wr_busy,
  input  logic                 shutdown,
  output logic [POSITIONS-1:0] char_en,
  output logic                 seg_en
);

  logic [POSITIONS-1:0] dec;
  gate_e                gate;
  logic [POSITIONS-1:0] char_q;
  logic                 seg_q;

  for (genvar g = 0; g < POSITIONS; g++) begin : g_dec
    assign dec[g] = (pos == POS_W'(g));
  end

  assign gate = pick_gate(shutdown, wr_busy, blank);

  always_ff @(posedge clk) begin
    if (rst) begin
      char_q <= '0;
      seg_q  <= 1'b0;
    end else begin
      char_q <= (gate == GATE_SHOW) ? dec : '0;
      seg_q  <= (gate == GATE_SHOW) || (gate == GATE_BLANK);
    end
  end

  assign char_en = char_q;
  assign seg_en  = seg_q;

  // R8: never two characters at once
  a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(char_q));

  // R6: a host write silences both outputs
  a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
    wr_busy |=> (char_q == '0) && !seg_q);

  // R7: shutdown silences both outputs
  a_r7_off: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> (char_q == '0) && !seg_q);

  // R5: the blanking gap removes every character enable
  a_r5_blank: assert property (@(posedge clk) disable iff (rst)
    blank |=> (char_q == '0));

endmodule

// File: rtl/display_scan_timer.sv
module display_scan_timer #(
  parameter int unsigned PRESCALE    = dscan_pkg::DEF_PRESCALE,
  parameter int unsigned POSITIONS   = dscan_pkg::DEF_POSITIONS,
  parameter int unsigned BLANK_TICKS = dscan_pkg::DEF_BLANK,
  localparam int unsigned PRE_W      = $clog2(PRESCALE),
  localparam int unsigned POS_W      = $clog2(POSITIONS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 osc_tick,
  input  logic                 shutdown,
  input  logic                 wr_busy,
  output logic [POS_W-1:0]     scan_addr,
  output logic [POSITIONS-1:0] char_en,
  output logic                 seg_en
);

  logic [PRE_W-1:0] pre_count;
  logic             pre_wrap;
  logic             pre_blank;
  logic [POS_W-1:0] pos;

  dscan_prescaler #(
    .PRESCALE    (PRESCALE),
    .BLANK_TICKS (BLANK_TICKS)
  ) u_pre (
    .clk   (clk),
    .rst   (rst),
    .tick  (osc_tick),
    .clear (shutdown),
    .count (pre_count),
    .wrap  (pre_wrap),
    .blank (pre_blank)
  );

  dscan_position #(
    .POSITIONS (POSITIONS)
  ) u_pos (
    .clk   (clk),
    .rst   (rst),
    .step  (pre_wrap),
    .clear (shutdown),
    .pos   (pos)
  );

  dscan_outputs #(
    .POSITIONS (POSITIONS)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .pos      (pos),
    .blank    (pre_blank),
    .wr_busy  (wr_busy),
    .shutdown (shutdown),
    .char_en  (char_en),
    .seg_en   (seg_en)
  );

  assign scan_addr = pos;

  // R2: the position moves only when the prescaler sits at its last count with a tick
  a_r2_wrap_only: assert property (@(posedge clk) disable iff (rst)
    (pos != $past(pos)) && !$past(shutdown) |-> $past(osc_tick) && ($past(pre_count) == PRE_W'(PRESCALE - 1)));

endmodule

// File: tb/sim_display_scan_timer.sv
`timescale 1ns/1ps
module sim_display_scan_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_tick = 1'b0;
  logic       shutdown = 1'b0;
  logic       wr_busy = 1'b0;
  logic [2:0] scan_addr;
  logic [7:0] char_en;
  logic       seg_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  display_scan_timer u0 (
    .clk       (clk),
    .rst       (rst),
    .osc_tick  (osc_tick),
    .shutdown  (shutdown),
    .wr_busy   (wr_busy),
    .scan_addr (scan_addr),
    .char_en   (char_en),
    .seg_en    (seg_en)
  );

  // Cycle model built from the requirements
  int         m_pre = 0;
  logic [2:0] m_pos = 3'd0;
  logic [7:0] e_char = 8'h00;
  logic       e_seg = 1'b0;
  string      e_why = "R1";

  function automatic logic [7:0] onehot_of(input logic [2:0] p);
    return 8'h01 << p;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pre <= 0; m_pos <= 3'd0; e_char <= 8'h00; e_seg <= 1'b0; e_why <= "R1";
    end else begin
      if (shutdown)          begin e_char <= 8'h00; e_seg <= 1'b0; e_why <= "R7"; end
      else if (wr_busy)      begin e_char <= 8'h00; e_seg <= 1'b0; e_why <= "R6"; end
      else if (m_pre == 0)   begin e_char <= 8'h00; e_seg <= 1'b1; e_why <= "R5"; end
      else                   begin e_char <= onehot_of(m_pos); e_seg <= 1'b1; e_why <= "R4"; end
      if (shutdown) begin
        m_pre <= 0; m_pos <= 3'd0;
      end else if (osc_tick) begin
        if (m_pre == 63) begin m_pre <= 0; m_pos <= m_pos + 3'd1; end
        else m_pre <= m_pre + 1;
      end
    end
  end

  task automatic expect_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // One cycle: compare at the falling edge, then drive the next inputs
  task automatic cyc(input logic t, input logic sd, input logic wb);
    @(negedge clk);
    expect_eq("R3", "scan_addr", int'(scan_addr), int'(m_pos));
    expect_eq(e_why, "char_en", int'(char_en), int'(e_char));
    expect_eq(e_why, "seg_en", int'(seg_en), int'(e_seg));
    osc_tick = t; shutdown = sd; wr_busy = wb;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] held;
    int run_len, first_len, rise0, rise1, cyc_i;
    logic [7:0] prev;
    void'($urandom(32'd5150));

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_eq("R1", "scan_addr in reset", int'(scan_addr), 0);
    expect_eq("R1", "char_en in reset", int'(char_en), 0);
    expect_eq("R1", "seg_en in reset", int'(seg_en), 0);
    rst = 1'b0;

    // R3/R4/R5: dense ticks, two full frames
    for (int i = 0; i < 1100; i++) cyc(1'b1, 1'b0, 1'b0);

    // R2: no ticks, position must hold
    held = scan_addr;
    for (int i = 0; i < 300; i++) cyc(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    expect_eq("R2", "scan_addr held without ticks", int'(scan_addr), int'(held));

    // R7: shutdown mid-scan, then release
    for (int i = 0; i < 100; i++) cyc(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'b1, 1'b0);
    @(negedge clk);
    expect_eq("R7", "scan_addr during shutdown", int'(scan_addr), 0);
    expect_eq("R7", "char_en during shutdown", int'(char_en), 0);
    expect_eq("R7", "seg_en during shutdown", int'(seg_en), 0);

    // R9/R7: release and measure slot width and frame period
    shutdown = 1'b0; osc_tick = 1'b1; wr_busy = 1'b0;
    run_len = 0; first_len = -1; rise0 = -1; rise1 = -1; prev = 8'h00;
    for (cyc_i = 0; cyc_i < 1200; cyc_i++) begin
      @(negedge clk);
      if (cyc_i == 0) begin
        expect_eq("R7", "resume at position 0", int'(scan_addr), 0);
        expect_eq("R7", "blank after release", int'(char_en), 0);
      end
      if (char_en == 8'h01) run_len++;
      else if (prev == 8'h01 && first_len < 0) first_len = run_len;
      if (char_en == 8'h01 && prev != 8'h01) begin
        if (rise0 < 0) rise0 = cyc_i; else if (rise1 < 0) rise1 = cyc_i;
      end
      prev = char_en;
    end
    expect_eq("R9", "slot length in cycles", first_len, 63);
    expect_eq("R9", "frame period in cycles", rise1 - rise0, 512);

    // R6: write burst mid-slot, counting continues
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 1'b1);
    @(negedge clk);
    expect_eq("R6", "char_en during write", int'(char_en), 0);
    expect_eq("R6", "seg_en during write", int'(seg_en), 0);

    // R2-R8: constrained random mix
    for (int i = 0; i < 30000; i++) begin
      logic t, sd, wb;
      t  = ($urandom % 4) != 0;
      sd = ($urandom % 200) == 0;
      wb = ($urandom % 16) == 0;
      cyc(t, sd, wb);
      if (^char_en === 1'bx || $countones(char_en) > 1) begin
        checks++; fails++;
        $display("FAIL R8 char_en not one-hot: actual=%0h expected=at most one bit", char_en);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule